// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the interrupt-side control state of a small processor: the status word (mode and interrupt-enable bits), its saved copy, the saved instruction address, the interrupt parameter, the vector base and a countdown timer driven by a microsecond tick. Four sources compete for service: system call and program error cannot be masked, while the timer and disk sources are recorded in pending flags and only serviced while the enable bit of the status word is set.

When a source wins, one clock edge saves the status word and the current instruction address, clears the status word, records the error code if there is one, and emits a one-cycle redirect strobe carrying the vector address (vector base plus four times the interrupt number). A return command restores the status word from its saved copy and redirects to the saved address. A small control-write port lets system software load the status word, the vector base and the timer. All pins are plain control pins; there is no streaming data path, so no valid/ready handshake is used.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the status word, the error parameter and all pending flags are 0, and the redirect strobe is low.
- R2: On taking an interrupt, in one edge the saved status word takes the status word, the status word becomes 0, the saved address takes `cur_ia`, and in the next cycle `redirect` is high for one cycle with `redirect_ia` equal to vector base + 4 × interrupt number.
- R3: Interrupt numbers are 0 for system call, 1 for timer, 2 for disk and 3 for program error.
- R4: A program error loads `ip_o` with `prog_err_code` (0 undefined instruction, 1 privileged instruction in user mode, 2 address out of bounds); other sources leave `ip_o` unchanged.
- R5: A return command, when no interrupt is taken in that cycle, loads the status word from its saved copy and redirects to the saved address one cycle later.
- R6: Status-word bit 1 is the interrupt enable; while it is 0, timer and disk events set pending flags and cause no redirect, and a pending event is taken once bit 1 is 1. A flag clears when its source is taken.
- R7: System call and program error are taken whatever the value of the status word.
- R8: Priority is program error, then system call, then timer, then disk.
- R9: The timer decrements once every `TICK_DIV` clocks, sets the timer pending flag on the edge it reaches 0, and stays at 0 without wrapping; loading it with 0 raises no request.
- R10: The control write port selects by `ctl_wr_sel`: 0 status word (bits 1:0), 1 vector base, 2 timer, 3 none; a timer load overrides a decrement in the same cycle.
- R11: In a cycle where an interrupt is taken, a return command and a control write are ignored; in a cycle with a return, a control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ia | input | XLEN | Address of the current instruction |
| syscall_req | input | 1 | System call request (pulse) |
| prog_err_req | input | 1 | Program error request (pulse) |
| prog_err_code | input | 2 | Error parameter accompanying a program error |
| disk_req | input | 1 | Disk completion event (pulse) |
| rti_cmd | input | 1 | Return-from-interrupt command |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wr_sel | input | 2 | Control register select |
| ctl_wr_data | input | XLEN | Control register write data |
| redirect | output | 1 | One-cycle strobe: fetch from redirect_ia |
| redirect_ia | output | XLEN | New instruction address |
| psw_o | output | 2 | Current status word (bit 0 mode, bit 1 enable) |
| ip_o | output | 2 | Interrupt parameter |

## Verification
The hardest situation to reach is both maskable flags pending together while an unmaskable pair arrives, because the timer must first be run to expiry under a cleared enable bit and the disk pulse must land in the same masked window. The stimulus masks interrupts, loads the timer with 1, waits out the prescaler, pulses the disk line, then fires system call and program error in one cycle; re-enabling afterwards drains timer before disk through successive returns, which a behavioural model tracks cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    IRQ_SYSCALL = 2'd0,
    IRQ_TIMER   = 2'd1,
    IRQ_DISK    = 2'd2,
    IRQ_PERR    = 2'd3
  } irq_num_e;

  typedef enum logic [1:0] {
    SEL_PSW  = 2'd0,
    SEL_IVA  = 2'd1,
    SEL_TMR  = 2'd2,
    SEL_NONE = 2'd3
  } ctl_sel_e;

  localparam int PSW_W      = 2;
  localparam int PSW_EN_BIT = 1;
endpackage

// File: rtl/irq_countdown.sv
module irq_countdown #(
  parameter int TMR_W    = 32,
  parameter int TICK_DIV = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expire,
  output logic [TMR_W-1:0] value
);
  logic             tick;
  logic [TMR_W-1:0] cnt_q;

  generate
    if (TICK_DIV <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = !load && tick && (cnt_q == TMR_W'(1));
  assign value  = cnt_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic     perr,
  input  logic     sysc,
  input  logic     enable,
  input  logic     pend_tmr,
  input  logic     pend_dsk,
  output logic     take,
  output irq_num_e num
);
  always_comb begin
    take = 1'b1;
    num  = IRQ_SYSCALL;
    if (perr)                      num = IRQ_PERR;
    else if (sysc)                 num = IRQ_SYSCALL;
    else if (enable && pend_tmr)   num = IRQ_TIMER;
    else if (enable && pend_dsk)   num = IRQ_DISK;
    else                           take = 1'b0;
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int TMR_W    = 32,
  parameter int TICK_DIV = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_ia,
  input  logic              syscall_req,
  input  logic              prog_err_req,
  input  logic [1:0]        prog_err_code,
  input  logic              disk_req,
  input  logic              rti_cmd,
  input  logic              ctl_wr_en,
  input  logic [1:0]        ctl_wr_sel,
  input  logic [XLEN-1:0]   ctl_wr_data,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_ia,
  output logic [PSW_W-1:0]  psw_o,
  output logic [1:0]        ip_o
);
  logic [PSW_W-1:0] psw_q, ipsw_q;
  logic [1:0]       ip_q;
  logic [XLEN-1:0]  iia_q, iva_q, redir_ia_q;
  logic             redir_q, pend_t_q, pend_d_q;
  logic             take_w, rti_do, wr_do, tmr_wr, expire_w;
  irq_num_e         num_w;
  logic [TMR_W-1:0] timer_val;
  logic [XLEN-1:0]  vec_off;

  irq_arbiter u_arb (
    .perr     (prog_err_req),
    .sysc     (syscall_req),
    .enable   (psw_q[PSW_EN_BIT]),
    .pend_tmr (pend_t_q),
    .pend_dsk (pend_d_q),
    .take     (take_w),
    .num      (num_w)
  );

  assign rti_do  = rti_cmd && !take_w;
  assign wr_do   = ctl_wr_en && !take_w && !rti_do;
  assign tmr_wr  = wr_do && (ctl_wr_sel == SEL_TMR);
  assign vec_off = XLEN'({num_w, 2'b00});

  irq_countdown #(.TMR_W(TMR_W), .TICK_DIV(TICK_DIV)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_wr),
    .load_val (ctl_wr_data[TMR_W-1:0]),
    .expire   (expire_w),
    .value    (timer_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q      <= '0;
      ipsw_q     <= '0;
      ip_q       <= '0;
      iia_q      <= '0;
      iva_q      <= '0;
      redir_ia_q <= '0;
      redir_q    <= 1'b0;
    end else begin
      redir_q <= take_w || rti_do;
      if (take_w) begin
        ipsw_q     <= psw_q;
        psw_q      <= '0;
        iia_q      <= cur_ia;
        redir_ia_q <= iva_q + vec_off;
        if (num_w == IRQ_PERR) ip_q <= prog_err_code;
      end else if (rti_do) begin
        psw_q      <= ipsw_q;
        redir_ia_q <= iia_q;
      end else if (wr_do) begin
        case (ctl_wr_sel)
          SEL_PSW: psw_q <= ctl_wr_data[PSW_W-1:0];
          SEL_IVA: iva_q <= ctl_wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_t_q <= 1'b0;
      pend_d_q <= 1'b0;
    end else begin
      if (expire_w) pend_t_q <= 1'b1;
      else if (take_w && num_w == IRQ_TIMER) pend_t_q <= 1'b0;
      if (disk_req) pend_d_q <= 1'b1;
      else if (take_w && num_w == IRQ_DISK) pend_d_q <= 1'b0;
    end
  end

  assign redirect    = redir_q;
  assign redirect_ia = redir_ia_q;
  assign psw_o       = psw_q;
  assign ip_o        = ip_q;
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int XLEN  = 32,
  parameter int TMR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             syscall_req,
  input logic             prog_err_req,
  input logic [1:0]       prog_err_code,
  input logic             rti_cmd,
  input logic             redirect,
  input logic [XLEN-1:0]  redirect_ia,
  input logic [1:0]       psw_o,
  input logic [1:0]       ip_o,
  input logic             take_w,
  input logic [XLEN-1:0]  iia_q,
  input logic [TMR_W-1:0] timer_val,
  input logic             tmr_wr
);
  a_r7_unmaskable_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (syscall_req || prog_err_req) |=> (redirect && psw_o == 2'b00));

  a_r4_ip_code: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err_req |=> (ip_o == $past(prog_err_code)));

  a_r6_masked_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!psw_o[1] && !syscall_req && !prog_err_req && !rti_cmd) |=> !redirect);

  a_r5_rti_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_cmd && !take_w) |=> (redirect && redirect_ia == $past(iia_q)));

  a_r9_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_val == '0 && !tmr_wr) |=> (timer_val == '0));

  a_r2_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !take_w && !rti_cmd) |=> !redirect);
endmodule

bind irq_sequencer irq_sequencer_chk #(.XLEN(XLEN), .TMR_W(TMR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .syscall_req   (syscall_req),
  .prog_err_req  (prog_err_req),
  .prog_err_code (prog_err_code),
  .rti_cmd       (rti_cmd),
  .redirect      (redirect),
  .redirect_ia   (redirect_ia),
  .psw_o         (psw_o),
  .ip_o          (ip_o),
  .take_w        (take_w),
  .iia_q         (iia_q),
  .timer_val     (timer_val),
  .tmr_wr        (tmr_wr)
);

// File: tb/irq_sequencer_bench.sv
module irq_sequencer_bench;
  localparam int XLEN = 32;
  localparam int DIV  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] cur_ia = '0;
  logic            syscall_req = 1'b0, prog_err_req = 1'b0, disk_req = 1'b0;
  logic            rti_cmd = 1'b0, ctl_wr_en = 1'b0;
  logic [1:0]      prog_err_code = '0, ctl_wr_sel = '0;
  logic [XLEN-1:0] ctl_wr_data = '0;
  logic            redirect;
  logic [XLEN-1:0] redirect_ia;
  logic [1:0]      psw_o, ip_o;

  always #5 clk = ~clk;

  irq_sequencer #(.XLEN(XLEN), .TMR_W(32), .TICK_DIV(DIV)) u_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .cur_ia(cur_ia), .syscall_req(syscall_req),
    .prog_err_req(prog_err_req), .prog_err_code(prog_err_code), .disk_req(disk_req),
    .rti_cmd(rti_cmd), .ctl_wr_en(ctl_wr_en), .ctl_wr_sel(ctl_wr_sel),
    .ctl_wr_data(ctl_wr_data), .redirect(redirect), .redirect_ia(redirect_ia),
    .psw_o(psw_o), .ip_o(ip_o)
  );

  // Behavioural reference model
  int unsigned m_psw, m_ipsw, m_ip, m_iia, m_iva, m_ia, m_timer, m_pre;
  bit          m_redir, m_pt, m_pd;
  int          checks = 0, fails = 0, cycles = 0;
  string       phase = "R1";
  int          redirects_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psw = 0; m_ipsw = 0; m_ip = 0; m_iia = 0; m_iva = 0; m_ia = 0;
      m_timer = 0; m_pre = 0; m_redir = 0; m_pt = 0; m_pd = 0;
    end else begin
      bit tick, take, rti_do, wr_do;
      int num;
      tick  = (m_pre == DIV - 1);
      m_pre = tick ? 0 : m_pre + 1;
      take = 1; num = 0;
      if (prog_err_req) num = 3;
      else if (syscall_req) num = 0;
      else if ((m_psw & 2) != 0 && m_pt) num = 1;
      else if ((m_psw & 2) != 0 && m_pd) num = 2;
      else take = 0;
      rti_do = rti_cmd && !take;
      wr_do  = ctl_wr_en && !take && !rti_do;
      m_redir = take || rti_do;
      if (take) begin
        m_ipsw = m_psw; m_psw = 0; m_iia = cur_ia;
        m_ia = m_iva + 4 * num;
        if (num == 3) m_ip = prog_err_code;
        if (num == 1) m_pt = 0;
        if (num == 2) m_pd = 0;
      end else if (rti_do) begin
        m_psw = m_ipsw; m_ia = m_iia;
      end
      if (wr_do && ctl_wr_sel == 2) m_timer = ctl_wr_data;
      else if (tick && m_timer != 0) begin
        m_timer = m_timer - 1;
        if (m_timer == 0) m_pt = 1;
      end
      if (disk_req) m_pd = 1;
      if (wr_do && ctl_wr_sel == 0) m_psw = ctl_wr_data & 3;
      if (wr_do && ctl_wr_sel == 1) m_iva = ctl_wr_data;
    end
  end

  task automatic chk(string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("redirect", redirect, m_redir);
    if (m_redir) begin
      chk("redirect_ia", redirect_ia, m_ia);
      redirects_seen++;
    end
    chk("psw", psw_o, m_psw);
    chk("ip", ip_o, m_ip);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(int sel, int unsigned data);
    ctl_wr_en = 1; ctl_wr_sel = sel[1:0]; ctl_wr_data = data;
    @(negedge clk); ctl_wr_en = 0; idle(1);
  endtask
  task automatic sc(int unsigned ia);
    syscall_req = 1; cur_ia = ia; @(negedge clk); syscall_req = 0; idle(2);
  endtask
  task automatic perr(int code, int unsigned ia);
    prog_err_req = 1; prog_err_code = code[1:0]; cur_ia = ia;
    @(negedge clk); prog_err_req = 0; idle(2);
  endtask
  task automatic rti();
    rti_cmd = 1; @(negedge clk); rti_cmd = 0; idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    phase = "R10"; wr(1, 32'h1000); wr(0, 2); wr(3, 32'hFFFF);
    phase = "R2_R3"; sc(32'h200);
    phase = "R5"; rti();
    phase = "R4"; perr(2, 32'h300); rti(); perr(1, 32'h304); rti();
    phase = "R6"; wr(0, 0);
    disk_req = 1; @(negedge clk); disk_req = 0; idle(6);
    wr(0, 2); idle(2); rti();
    phase = "R9"; wr(2, 3); idle(16); rti(); idle(20);
    wr(2, 0); idle(12);
    phase = "R8"; wr(0, 0); wr(2, 1); idle(8);
    disk_req = 1; @(negedge clk); disk_req = 0; idle(1);
    syscall_req = 1; prog_err_req = 1; prog_err_code = 0; cur_ia = 32'h400;
    @(negedge clk); syscall_req = 0; prog_err_req = 0; idle(2);
    rti();
    wr(0, 2); idle(2); rti(); idle(2); rti();
    phase = "R7"; wr(0, 0); sc(32'h500); rti();
    phase = "R11"; rti_cmd = 1; syscall_req = 1; cur_ia = 32'h600;
    @(negedge clk); rti_cmd = 0; syscall_req = 0; idle(2);
    ctl_wr_en = 1; ctl_wr_sel = 0; ctl_wr_data = 3; syscall_req = 1;
    @(negedge clk); ctl_wr_en = 0; syscall_req = 0; idle(2);
    ctl_wr_en = 1; ctl_wr_sel = 0; ctl_wr_data = 1; rti_cmd = 1;
    @(negedge clk); ctl_wr_en = 0; rti_cmd = 0; idle(3);
    phase = "R1"; rst_n = 0; idle(2); rst_n = 1; idle(2);
    phase = "R2"; chk("redirects observed", redirects_seen >= 14, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule